// File: doc/BRIEF.md
# Dual converter divided-clock phase aligner

This controller runs once after power-up to bring the divided output clocks of two high-speed converters into the same phase. Each converter divides its sample clock by four. That divider starts in an arbitrary state, so the relative phase of the two divided clocks is one of four quarter-cycle offsets. A separate phase detector reports this offset as a 2-bit code. The controller reads the code and acts on it. If the offset is non-zero, it resets the second converter only, waits for that converter's clock to restart, and measures again.

The loop ends in one of two ways. Either the two clocks agree and the block reports lock, or a configurable number of resets has been spent and the block reports failure. After failure it issues no further resets until software starts it again. An attempt count is available on the ports, so software can see how many resets were needed. To stop a jittery reading from causing a wrong decision, a code is acted on only after it has been seen the same on several consecutive cycles.

Top module: `adc_phase_align`

## Requirements
- R1: After synchronous reset, `conv_rst`, `done`, `locked` and `timeout` are 0 and `attempts` is 0. With `start` held low the block stays idle and issues no converter reset, whatever `phase_diff` shows.
- R2: A `start` pulse is accepted while idle, locked or failed. On the next cycle `done`, `locked`, `timeout` and `attempts` are cleared. The first comparison then begins after `SETTLE_CYC` cycles, so the first reset pulse, if any, follows `SETTLE_CYC + VOTES` low cycles after the start edge.
- R3: A phase code is acted on only after `VOTES` consecutive identical samples. A code that changes more often than that causes neither lock nor a converter reset.
- R4: Code 0 means aligned (codes 1, 2 and 3 mean one, two or three quarter-cycles apart). An agreed code 0 sets `locked` and `done` and issues no reset.
- R5: An agreed non-zero code, with the attempt limit not yet reached, drives `conv_rst` high for exactly `RST_PULSE_CYC` cycles.
- R6: After each reset pulse the block ignores `phase_diff` for `SETTLE_CYC` cycles and then compares again. With a stable code, consecutive pulses are separated by exactly `SETTLE_CYC + VOTES` low cycles.
- R7: Once `MAX_ATTEMPTS` resets have been issued, a further agreed non-zero code sets `timeout` and `done`. No more pulses are issued until the next `start`.
- R8: `attempts` increments on every reset pulse, equals the number of pulses issued since the last start, and holds its value after the run ends.
- R9: `locked` and `timeout` are never high together, and `done` is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) an alignment run |
| phase_diff | input | 2 | Measured quarter-cycle offset of the second divided clock relative to the first; 0 means aligned |
| conv_rst | output | 1 | Reset pulse to the second converter |
| done | output | 1 | Run finished (locked or timed out) |
| locked | output | 1 | Divided clocks agree |
| timeout | output | 1 | Attempt limit exhausted without alignment |
| attempts | output | $clog2(MAX_ATTEMPTS+1) | Reset pulses issued in the current run |

## Verification
The assertions assume that `phase_diff` comes from a detector whose reading settles after each restart. They also assume that `start` is only meaningful while the block is idle or finished. They do not depend on the value of the code, only on the order of states the controller goes through. The stimulus follows these assumptions. The converter model changes its code only on the falling edge of `conv_rst` and holds it stable until the next pulse. The one exception is a dedicated test that cycles the code faster than the vote depth, to exercise the filter. `start` is pulsed only once each run has finished.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_COMPARE,
        ST_RESET_ADC,
        ST_WAIT_RESTART,
        ST_LOCKED,
        ST_FAIL
    } align_state_e;

    typedef logic [1:0] quad_phase_t;

    localparam quad_phase_t PHASE_MATCH = 2'd0;

    typedef struct packed {
        logic done;
        logic locked;
        logic timeout;
    } align_status_t;

    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/phase_agree.sv
module phase_agree
    import adc_align_pkg::*;
#(
    parameter int unsigned VOTES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  quad_phase_t sample,
    output logic        agree,
    output quad_phase_t agreed
);
    localparam int unsigned CW = width_for(VOTES);
    localparam logic [CW-1:0] LAST_RUN = CW'(VOTES - 1);

    logic [CW-1:0] run_len;
    quad_phase_t   held;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_len <= '0;
            held    <= '0;
        end else if (run_len == '0 || sample != held) begin
            held    <= sample;
            run_len <= CW'(1);
        end else if (run_len != LAST_RUN) begin
            run_len <= run_len + CW'(1);
        end
    end

    assign agree  = en && (run_len == LAST_RUN) && (sample == held);
    assign agreed = held;

    // R3: a decision is never taken on a reading that differs from the previous cycle
    assert_vote_stable_R3: assert property (@(posedge clk) disable iff (rst)
        agree |-> (sample == $past(sample)));

endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - W'(1);
    end

    assign expired = (remain == '0);

    // R5: a running count only ever moves down by one unless reloaded
    assert_timer_step_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(remain) != '0) |-> (remain == $past(remain) - W'(1)));

endmodule

// File: rtl/adc_phase_align.sv
module adc_phase_align
    import adc_align_pkg::*;
#(
    parameter int unsigned RST_PULSE_CYC = 16,
    parameter int unsigned SETTLE_CYC    = 256,
    parameter int unsigned MAX_ATTEMPTS  = 64,
    parameter int unsigned VOTES         = 4,
    localparam int unsigned AW           = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    phase_diff,
    output logic          conv_rst,
    output logic          done,
    output logic          locked,
    output logic          timeout,
    output logic [AW-1:0] attempts
);
    localparam int unsigned TW = width_for(larger(RST_PULSE_CYC, SETTLE_CYC));
    localparam logic [TW-1:0] RST_LOAD    = TW'(RST_PULSE_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LOAD = TW'(SETTLE_CYC - 1);
    localparam logic [AW-1:0] ATT_CAP     = AW'(MAX_ATTEMPTS);

    align_state_e  state;
    align_status_t stat;
    logic [AW-1:0] att_q;

    logic          vote_en, vote_ok;
    quad_phase_t   vote_val;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          restartable;

    assign restartable = (state == ST_IDLE) || (state == ST_LOCKED) || (state == ST_FAIL);
    assign vote_en     = (state == ST_COMPARE);

    phase_agree #(.VOTES(VOTES)) u_vote (
        .clk    (clk),
        .rst    (rst),
        .en     (vote_en),
        .sample (quad_phase_t'(phase_diff)),
        .agree  (vote_ok),
        .agreed (vote_val)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = SETTLE_LOAD;
        if (restartable && start) begin
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LOAD;
        end else if (state == ST_COMPARE && vote_ok && vote_val != PHASE_MATCH
                     && att_q != ATT_CAP) begin
            tmr_load = 1'b1;
            tmr_val  = RST_LOAD;
        end else if (state == ST_RESET_ADC && tmr_done) begin
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LOAD;
        end
    end

    hold_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            stat  <= '0;
            att_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_LOCKED, ST_FAIL: begin
                    if (start) begin
                        state <= ST_SETTLE;
                        stat  <= '0;
                        att_q <= '0;
                    end
                end
                ST_SETTLE: begin
                    if (tmr_done) state <= ST_COMPARE;
                end
                ST_COMPARE: begin
                    if (vote_ok) begin
                        if (vote_val == PHASE_MATCH) begin
                            state       <= ST_LOCKED;
                            stat.done   <= 1'b1;
                            stat.locked <= 1'b1;
                        end else if (att_q == ATT_CAP) begin
                            state        <= ST_FAIL;
                            stat.done    <= 1'b1;
                            stat.timeout <= 1'b1;
                        end else begin
                            state <= ST_RESET_ADC;
                            att_q <= att_q + AW'(1);
                        end
                    end
                end
                ST_RESET_ADC: begin
                    if (tmr_done) state <= ST_WAIT_RESTART;
                end
                ST_WAIT_RESTART: begin
                    if (tmr_done) state <= ST_COMPARE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign conv_rst = (state == ST_RESET_ADC);
    assign done     = stat.done;
    assign locked   = stat.locked;
    assign timeout  = stat.timeout;
    assign attempts = att_q;

    // R7: attempt count never passes its cap
    assert_att_cap_R7: assert property (@(posedge clk) disable iff (rst)
        attempts <= ATT_CAP);

    // R7: a timed-out controller is silent
    assert_quiet_fail_R7: assert property (@(posedge clk) disable iff (rst)
        timeout |-> !conv_rst);

    // R8: every new pulse advances the count by one
    assert_count_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_rst) |-> (attempts == $past(attempts) + AW'(1)));

    // R9: outcomes are exclusive and done reflects exactly one
    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        done == (locked ^ timeout));

    // R4: lock is only declared while no reset is in flight
    assert_lock_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        locked |-> !conv_rst);

endmodule

// File: tb/sim_adc_phase_align.sv
module sim_adc_phase_align;
    localparam int RST_CYC = 3;
    localparam int SETTLE  = 5;
    localparam int MAX_ATT = 6;
    localparam int VOTES   = 4;
    localparam int AW      = $clog2(MAX_ATT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    phase_diff;
    logic          conv_rst, done, locked, timeout;
    logic [AW-1:0] attempts;

    always #4 clk = ~clk;

    adc_phase_align #(
        .RST_PULSE_CYC(RST_CYC), .SETTLE_CYC(SETTLE),
        .MAX_ATTEMPTS(MAX_ATT), .VOTES(VOTES)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .phase_diff(phase_diff),
        .conv_rst(conv_rst), .done(done), .locked(locked),
        .timeout(timeout), .attempts(attempts)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // converter + detector model
    logic [1:0] model_ph = 2'd3;
    logic [7:0] lfsr = 8'h5a;
    bit  force_bad = 0, alt_mode = 0, track_gap = 0, rst_q = 0, finished = 0;
    int  pulses = 0, width = 0, gap = 0, first_zero = -1, cyc = 0;

    assign phase_diff = alt_mode ? (((cyc / 3) % 2) != 0 ? 2'd1 : 2'd2) : model_ph;

    always @(negedge clk) begin
        cyc++;
        if (conv_rst) width++;
        if (rst_q && !conv_rst) begin
            check(width == RST_CYC, "R5 pulse width", width, RST_CYC);
            width = 0;
            pulses++;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            model_ph = force_bad ? 2'(1 + (lfsr % 3)) : lfsr[1:0];
            if (model_ph == 2'd0 && first_zero < 0) first_zero = pulses;
            gap = 1;
            track_gap = 1;
        end else if (!rst_q && conv_rst) begin
            if (track_gap)
                check(gap == SETTLE + VOTES, "R6 spacing (R2 for first pulse)", gap, SETTLE + VOTES);
        end else if (!conv_rst && track_gap) begin
            gap++;
        end
        rst_q = conv_rst;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); #1;
        pulses = 0; width = 0; gap = 0; track_gap = 1;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        check(!done && !locked && !timeout, "R2 status cleared", {done, locked, timeout}, 0);
        check(attempts == 0, "R2 attempts cleared", int'(attempts), 0);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic run_trial(input logic [1:0] init, input bit bad, input logic [7:0] seed);
        int exp_att;
        bit exp_lock;
        int held;
        @(negedge clk); #1;
        lfsr = seed; force_bad = bad; model_ph = init;
        first_zero = (init == 2'd0) ? 0 : -1;
        pulse_start();
        wait_done();
        exp_lock = (first_zero >= 0 && first_zero <= MAX_ATT);
        exp_att  = exp_lock ? first_zero : MAX_ATT;
        check(done == 1'b1, "R4/R7 done", int'(done), 1);
        check(locked == exp_lock, "R4 locked", int'(locked), int'(exp_lock));
        check(timeout == !exp_lock, "R7 timeout", int'(timeout), int'(!exp_lock));
        check(int'(attempts) == exp_att, "R8 attempts", int'(attempts), exp_att);
        check(pulses == exp_att, "R8 pulse count", pulses, exp_att);
        held = pulses;
        repeat (40) @(negedge clk);
        check(pulses == held, "R7 no further pulses", pulses, held);
        check(int'(attempts) == exp_att, "R8 attempts held", int'(attempts), exp_att);
        check(locked == exp_lock && timeout == !exp_lock, "R9 outcome held",
              {locked, timeout}, {exp_lock, !exp_lock});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state and idle without start
        check(!conv_rst && !done && !locked && !timeout, "R1 reset outputs",
              {conv_rst, done, locked, timeout}, 0);
        check(attempts == 0, "R1 reset attempts", int'(attempts), 0);
        repeat (20) @(negedge clk);
        check(pulses == 0 && !done, "R1 idle without start", pulses, 0);

        // R3: readings that never agree for VOTES cycles trigger nothing
        @(negedge clk); #1;
        alt_mode = 1; model_ph = 2'd0; first_zero = 0;
        pulse_start();
        repeat (60) @(negedge clk);
        check(pulses == 0, "R3 no reset on unstable code", pulses, 0);
        check(!done && !locked, "R3 no lock on unstable code", {done, locked}, 0);
        #1 alt_mode = 0;
        wait_done();
        check(locked && attempts == 0, "R3/R4 lock once stable", int'(locked), 1);

        // sweep of initial phases and restart sequences
        for (int s = 0; s < 12; s++)
            run_trial(2'(s % 4), 1'b0, 8'(1 + s * 37));
        // alignment never reachable: forced timeout, then restart
        for (int k = 1; k < 4; k++)
            run_trial(2'(k), 1'b1, 8'(11 * k + 3));
        run_trial(2'd2, 1'b0, 8'h93);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule